// File: doc/BRIEF.md
# Two-Stage Pipelined Four-Instruction Core with Result Forwarding

This block is a small processor core built as two overlapping stages. It runs a four-instruction set: register add, branch-if-zero, load and store. In every cycle the front stage reads the instruction word at the program counter, looks up its operand values, and writes a decoded template with a valid flag into one pipeline register. In the same cycle the back stage acts on the template already in that register. It writes the register file, drives the data-memory port, or redirects the program counter.

Fetch always guesses the next address is pc+1. A branch-if-zero whose condition value is zero is resolved in the back stage. It loads the branch target into pc and empties the pipeline register, so the instruction fetched in that cycle is thrown away. The add sum or the loaded word being written in the back stage is forwarded into the operand lookup of the front stage. A dependent instruction right behind a producer therefore needs no stall, and the core issues one instruction per cycle except after a taken branch.

Both memories respond within the same cycle. The instruction port is read combinationally from `imem_addr`. The data port returns `dmem_rdata` for `dmem_addr` in the same cycle and stores at the clock edge when `dmem_we` is high. With the default parameters there are 8 registers of 16 bits and an 8-bit instruction address.

Top module: `pipe2_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `imem_addr` is 0 and `dmem_we` is 0. All registers reset to 0 and the pipeline register resets to empty.
- R2: When no taken branch is in the back stage, `imem_addr` advances by exactly one every cycle (fetch predicts pc+1).
- R3: An add writes reg[f1] = reg[f2] + reg[f3], modulo 2^DW. A later instruction sees the result.
- R4: A load writes reg[f1] = mem[reg[f2]]. A store fetched in cycle c drives `dmem_we`=1, `dmem_addr`=reg[f2] and `dmem_wdata`=reg[f1] in cycle c+1. `dmem_we` is high only in such cycles.
- R5: A branch-if-zero fetched in cycle c with reg[f1]==0 drives `imem_addr`=pc+1 in cycle c+1 and then the low AW bits of reg[f2] in cycle c+2. The instruction fetched in cycle c+1 has no effect.
- R6: A branch-if-zero with reg[f1]!=0 has no effect except that fetch carries on at pc+1 with no bubble.
- R7: The instruction after an add or a load reads that producer's result in the very next cycle, with no stall cycle.
- R8: For any program, each cycle's `imem_addr` and store activity match a sequential model of the instruction set that charges one cycle per instruction plus one extra cycle per taken branch.
- R9: An instruction word is {op[1:0], f1, f2, f3}, each field log2(NREG) bits wide (bits 10:9, 8:6, 5:3, 2:0 by default). The op codes are 00 add, 01 branch-if-zero, 10 load and 11 store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | AW | Current fetch address (pc) |
| imem_data | input | 2+3*log2(NREG) | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | DW | Data address for a load or store in the back stage |
| dmem_rdata | input | DW | Data read at `dmem_addr`, same cycle |
| dmem_we | output | 1 | Store strobe; memory writes at the clock edge |
| dmem_wdata | output | DW | Store data |

## Verification
A corrupt register value or a stale operand appears on `dmem_addr` or `dmem_wdata` at the next store that uses it. A wrong branch condition or target bends the `imem_addr` trace within two cycles. A forwarding fault shows up only when a consumer directly follows its producer, so the directed programs chain loads and adds back to back. The randomly generated programs then compare fetch address and store traffic in every cycle against a sequential model.

// File: rtl/pipe2_core.sv
module pipe2_core #(
  parameter int DW = 16,
  parameter int NREG = 8,
  parameter int AW = 8,
  localparam int RW = $clog2(NREG),
  localparam int IW = 2 + 3 * RW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [IW-1:0] imem_data,
  output logic [DW-1:0] dmem_addr,
  input  logic [DW-1:0] dmem_rdata,
  output logic          dmem_we,
  output logic [DW-1:0] dmem_wdata
);
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_BZ  = 2'b01;
  localparam logic [1:0] OP_LD  = 2'b10;
  localparam logic [1:0] OP_ST  = 2'b11;

  logic [DW-1:0] rf [NREG];
  logic [AW-1:0] pc;

  logic          pv;
  logic [1:0]    pk;
  logic [RW-1:0] pd;
  logic [DW-1:0] pa, pb;

  wire [1:0]    op = imem_data[IW-1 -: 2];
  wire [RW-1:0] f1 = imem_data[3*RW-1 -: RW];
  wire [RW-1:0] f2 = imem_data[2*RW-1 -: RW];
  wire [RW-1:0] f3 = imem_data[RW-1:0];

  wire ex_add = pv && pk == OP_ADD;
  wire ex_bz  = pv && pk == OP_BZ;
  wire ex_ld  = pv && pk == OP_LD;
  wire ex_st  = pv && pk == OP_ST;

  wire          fwd_v   = ex_add || ex_ld;
  wire [DW-1:0] fwd_val = ex_add ? pa + pb : dmem_rdata;
  wire          taken   = ex_bz && pa == '0;

  assign imem_addr  = pc;
  assign dmem_addr  = pb;
  assign dmem_we    = ex_st;
  assign dmem_wdata = pa;

  function automatic logic [DW-1:0] opnd(input logic [RW-1:0] idx);
    return (fwd_v && idx == pd) ? fwd_val : rf[idx];
  endfunction

  wire [DW-1:0] n_a = (op == OP_LD) ? '0 : (op == OP_ADD) ? opnd(f2) : opnd(f1);
  wire [DW-1:0] n_b = (op == OP_ADD) ? opnd(f3) : opnd(f2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      pv <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (fwd_v) rf[pd] <= fwd_val;
      if (taken) begin
        pc <= AW'(pb);
        pv <= 1'b0;
      end else begin
        pc <= pc + AW'(1);
        pv <= 1'b1;
        pk <= op;
        pd <= f1;
        pa <= n_a;
        pb <= n_b;
      end
    end
  end
endmodule

module pipe2_core_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] imem_addr,
  input logic          dmem_we,
  input logic          pv,
  input logic [1:0]    pk,
  input logic [DW-1:0] pa,
  input logic [DW-1:0] pb,
  input logic          fwd_v
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (imem_addr == '0 && !pv && !dmem_we));

  // R5
  branch_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && pk == 2'b01 && pa == '0) |=> (imem_addr == $past(AW'(pb)) && !pv));

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pv && pk == 2'b01 && pa == '0) |=> (imem_addr == $past(imem_addr) + AW'(1) && pv));

  // R4
  store_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (pv && pk == 2'b11));

  // R7
  fwd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_v |-> (pv && (pk == 2'b00 || pk == 2'b10)));
endmodule

bind pipe2_core pipe2_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .dmem_we(dmem_we),
  .pv(pv), .pk(pk), .pa(pa), .pb(pb), .fwd_v(fwd_v)
);

// File: tb/sim_pipe2_core.sv
`timescale 1ns/1ps
module sim_pipe2_core;
  localparam int NC = 64;

  logic clk = 0, rst_n = 0;
  logic [7:0]  imem_addr;
  logic [10:0] imem_data;
  logic [15:0] dmem_addr, dmem_rdata, dmem_wdata;
  logic        dmem_we;

  logic [10:0] prog [256];
  logic [15:0] bmem [256];
  logic [15:0] mem0 [256];

  logic [7:0]  exp_pc [NC];
  logic        exp_we [NC];
  logic [15:0] exp_a  [NC];
  logic [15:0] exp_d  [NC];

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pipe2_core u0 (.clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata));

  assign imem_data  = prog[imem_addr];
  assign dmem_rdata = bmem[dmem_addr[7:0]];
  always @(posedge clk) if (dmem_we) bmem[dmem_addr[7:0]] <= dmem_wdata;

  function automatic logic [10:0] enc(input logic [1:0] o, input int a, input int b, input int c);
    return {o, 3'(a), 3'(b), 3'(c)};
  endfunction

  task automatic chk(input string tag, input string what, input int c, input logic [15:0] got, input logic [15:0] ex);
    total++;
    if (got !== ex) begin
      bad++;
      $display("FAIL %s %s cycle %0d got %0h exp %0h", tag, what, c, got, ex);
    end
  endtask

  task automatic build_expect();
    logic [15:0] r [8];
    logic [15:0] m [256];
    logic [7:0]  pc;
    logic [10:0] w;
    int c;
    for (int i = 0; i < 8; i++) r[i] = '0;
    for (int i = 0; i < 256; i++) m[i] = mem0[i];
    for (int i = 0; i < NC; i++) begin exp_pc[i] = '0; exp_we[i] = 0; exp_a[i] = '0; exp_d[i] = '0; end
    pc = '0; c = 0;
    while (c < NC - 1) begin
      w = prog[pc];
      exp_pc[c] = pc;
      case (w[10:9])
        2'b00: begin r[w[8:6]] = r[w[5:3]] + r[w[2:0]]; pc++; c++; end
        2'b01: if (r[w[8:6]] == '0) begin
                 exp_pc[c+1] = pc + 8'd1;
                 pc = r[w[5:3]][7:0]; c += 2;
               end else begin pc++; c++; end
        2'b10: begin r[w[8:6]] = m[r[w[5:3]][7:0]]; pc++; c++; end
        default: begin
          exp_we[c+1] = 1; exp_a[c+1] = r[w[5:3]]; exp_d[c+1] = r[w[8:6]];
          m[r[w[5:3]][7:0]] = r[w[8:6]]; pc++; c++;
        end
      endcase
    end
    if (c < NC) exp_pc[c] = pc;
  endtask

  task automatic run_prog(input string pctag, input string sttag);
    for (int i = 0; i < 256; i++) bmem[i] = mem0[i];
    build_expect();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset imem_addr", -1, 16'(imem_addr), 16'h0);
    chk("R1", "reset dmem_we", -1, 16'(dmem_we), 16'h0);
    rst_n = 1;
    for (int c = 0; c < NC; c++) begin
      chk(c == 0 ? "R1" : pctag, "imem_addr", c, 16'(imem_addr), 16'(exp_pc[c]));
      chk(c == 0 ? "R1" : sttag, "dmem_we", c, 16'(dmem_we), 16'(exp_we[c]));
      if (exp_we[c] && dmem_we) begin
        chk(sttag, "dmem_addr", c, dmem_addr, exp_a[c]);
        chk(sttag, "dmem_wdata", c, dmem_wdata, exp_d[c]);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog got running exp finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));

    // R7 R3 R4 R2: back-to-back load-use and add chains
    for (int i = 0; i < 256; i++) begin prog[i] = '0; mem0[i] = '0; end
    mem0[0] = 16'd7; mem0[7] = 16'd100;
    prog[0] = enc(2'b10, 1, 0, 0);
    prog[1] = enc(2'b10, 2, 1, 0);
    prog[2] = enc(2'b00, 3, 1, 2);
    prog[3] = enc(2'b00, 3, 3, 3);
    prog[4] = enc(2'b11, 3, 1, 0);
    prog[5] = enc(2'b11, 2, 3, 0);
    prog[6] = enc(2'b00, 4, 3, 2);
    prog[7] = enc(2'b11, 4, 4, 0);
    run_prog("R2", "R7");
    chk("R3", "mem[7] after add chain", 0, bmem[7], 16'd214);
    chk("R4", "mem[214] store", 0, bmem[214], 16'd100);

    // R5 R6: not-taken branch, taken branch killing the next slot, loop back
    for (int i = 0; i < 256; i++) begin prog[i] = '0; mem0[i] = '0; end
    mem0[0] = 16'd9;
    prog[0]  = enc(2'b10, 1, 0, 0);
    prog[1]  = enc(2'b01, 1, 1, 0);
    prog[2]  = enc(2'b01, 0, 1, 0);
    prog[3]  = enc(2'b11, 1, 1, 0);
    for (int i = 4; i < 9; i++) prog[i] = enc(2'b11, 0, 0, 0);
    prog[9]  = enc(2'b11, 1, 0, 0);
    prog[10] = enc(2'b00, 2, 1, 1);
    prog[11] = enc(2'b11, 2, 0, 0);
    prog[12] = enc(2'b01, 0, 0, 0);
    run_prog("R5", "R6");
    chk("R5", "killed store left mem[9]", 0, bmem[9], 16'd0);

    // R8 R9: random programs against the sequential model
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 256; i++) begin
        int sel;
        sel = $urandom % 10;
        prog[i] = enc(sel < 3 ? 2'b00 : sel < 6 ? 2'b10 : sel < 9 ? 2'b11 : 2'b01,
                      $urandom % 8, $urandom % 8, $urandom % 8);
        mem0[i] = (($urandom % 4) == 0) ? 16'd0 : 16'($urandom);
      end
      run_prog("R8", "R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule